// File: doc/BRIEF.md
# Pseudo-SRAM Standby Mode Controller

This block decides the standby power state of a self-refreshing DRAM-based static memory. It watches an active-low sleep pin and a sleep-select bit in an 8-bit configuration register. When the pin has been held low long enough, the block enters one of two states. With the select bit set it enters partial refresh, where refresh is kept over the whole array or over none of it. With the select bit clear it enters deep power-down, where all refresh stops. While the memory sleeps, and while it re-initializes after deep power-down, read and write commands are refused.

A configuration-write strobe stands in for the unlock sequence software would use to reach the register. A software write with the select bit set moves the memory straight into partial refresh. The first accepted software write also sets a lock, and the lock stays until power-on reset. While the lock is set, a low pin can no longer start partial refresh, but it can still start deep power-down when the select bit is clear. All time thresholds are cycle counts derived from a clock-frequency parameter in MHz.

Top module: `psram_sleep_ctrl`

## Requirements
- R1: A low-power mode is entered only if `sleep_n` is sampled low on more than LOW_CYC = CLK_MHZ*LOW_US consecutive rising edges. A low run of LOW_CYC edges or fewer changes nothing. When the run reaches LOW_CYC+1 edges, the mode changes on the next edge.
- R2: With configuration bit 4 = 1 and the lock clear, a qualified low pin enters partial refresh (`mode` = 1). Configuration bit 0 selects the scope: 1 keeps refresh over the full array (`refresh_en` = 1, `refresh_full` = 1); 0 refreshes nothing (`refresh_en` = 0, `refresh_full` = 0).
- R3: With configuration bit 4 = 0, a qualified low pin enters deep power-down (`mode` = 2), with `refresh_en` = 0 and `refresh_full` = 0.
- R4: Partial refresh entered from the pin returns to active (`mode` = 0) on the first edge that samples `sleep_n` high, with no delay.
- R5: In deep power-down, an edge that samples `sleep_n` high enters initialization (`mode` = 3). Initialization lasts exactly INIT_CYC = CLK_MHZ*INIT_US cycles and then the block returns to active.
- R6: `cmd_rd_ok` and `cmd_wr_ok` follow `cmd_rd` and `cmd_wr` only in active mode and are 0 in every other mode. `busy` is 1 in every mode except active.
- R7: A configuration write with bit 4 = 1, made in active mode, enters partial refresh on the same edge. This partial refresh is left only after `sleep_n` has been sampled low and then sampled high.
- R8: Once any configuration write has been accepted, a qualified low pin with bit 4 = 1 no longer changes the mode. The lock is cleared only by `rst`.
- R9: A configuration write can never cause deep power-down. A write with bit 4 = 0 in active mode leaves the block active.
- R10: Configuration writes are accepted in active mode and in partial refresh. In deep power-down and during initialization they leave `cfg_q` unchanged.
- R11: After `rst`, the block is active (`mode` = 0), with `busy` = 0, `refresh_en` = 1, `refresh_full` = 1, `data_lost` = 0, `cfg_q` = 8'h11 and the lock clear.
- R12: `data_lost` is set one cycle after the block is in deep power-down, or in partial refresh with scope none. It then stays set until `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| sleep_n | input | 1 | Active-low sleep pin |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data (bit 4 sleep select, bit 0 refresh scope) |
| cmd_rd | input | 1 | Read request |
| cmd_wr | input | 1 | Write request |
| cmd_rd_ok | output | 1 | Read request passed to the array |
| cmd_wr_ok | output | 1 | Write request passed to the array |
| busy | output | 1 | Memory not available |
| mode | output | 2 | 0 active, 1 partial refresh, 2 deep power-down, 3 initializing |
| refresh_en | output | 1 | Refresh engine enable |
| refresh_full | output | 1 | Refresh scope is the full array |
| data_lost | output | 1 | Sticky flag: stored contents may be corrupted |
| cfg_q | output | 8 | Configuration register contents |

## Verification
The bench builds the block with CLK_MHZ = 1, LOW_US = 10 and INIT_US = 150, which gives a 10-cycle qualification threshold and a 150-cycle initialization window. With these values the bench can sweep every low-pulse length from 1 to LOW_CYC+2 cycles and confirm that exactly one boundary separates ignored pulses from mode entry. It can also count the full initialization window cycle by cycle and check that commands are refused on its last cycle and accepted on the next one.

// File: rtl/psram_sleep_pkg.sv
package psram_sleep_pkg;

    localparam int CFG_W     = 8;
    localparam int SEL_BIT   = 4;
    localparam int SCOPE_BIT = 0;
    localparam logic [CFG_W-1:0] CFG_RESET = 8'h11;

    typedef enum logic [1:0] {
        PM_ACTIVE  = 2'd0,
        PM_PARTIAL = 2'd1,
        PM_DEEP    = 2'd2,
        PM_INIT    = 2'd3
    } pmode_t;

    typedef struct packed {
        logic en;
        logic full;
    } refresh_t;

    function automatic int us_to_cycles(input int mhz, input int us);
        return mhz * us;
    endfunction

    function automatic refresh_t refresh_for(input pmode_t m, input logic scope_full);
        refresh_t r;
        case (m)
            PM_DEEP:    r = '{en: 1'b0, full: 1'b0};
            PM_PARTIAL: r = '{en: scope_full, full: scope_full};
            default:    r = '{en: 1'b1, full: 1'b1};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/psram_low_qual.sv
module psram_low_qual #(
    parameter int LOW_CYC = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep_n,
    output logic qual
);
    localparam int CW = $clog2(LOW_CYC + 2);
    localparam logic [CW-1:0] LIM = CW'(LOW_CYC);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || sleep_n) begin
            cnt <= '0;
        end else if (cnt <= LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign qual = (cnt > LIM);
endmodule

// File: rtl/psram_init_timer.sv
module psram_init_timer #(
    parameter int INIT_CYC = 150
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(INIT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(INIT_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == LAST);
endmodule

// File: rtl/psram_mode_fsm.sv
module psram_mode_fsm
    import psram_sleep_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sleep_n,
    input  logic   qual,
    input  logic   sel_partial,
    input  logic   lock,
    input  logic   wr_acc,
    input  logic   wr_sel,
    input  logic   init_done,
    output pmode_t mode
);
    pmode_t st, nx;
    logic   armed, armed_nx;

    always_comb begin
        nx       = st;
        armed_nx = armed;
        case (st)
            PM_ACTIVE: begin
                if (wr_acc) begin
                    if (wr_sel) begin
                        nx       = PM_PARTIAL;
                        armed_nx = 1'b0;
                    end
                end else if (qual) begin
                    if (!sel_partial) begin
                        nx = PM_DEEP;
                    end else if (!lock) begin
                        nx       = PM_PARTIAL;
                        armed_nx = 1'b1;
                    end
                end
            end
            PM_PARTIAL: begin
                armed_nx = armed | ~sleep_n;
                if (armed && sleep_n) nx = PM_ACTIVE;
            end
            PM_DEEP: begin
                if (sleep_n) nx = PM_INIT;
            end
            PM_INIT: begin
                if (init_done) nx = PM_ACTIVE;
            end
            default: nx = PM_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= PM_ACTIVE;
            armed <= 1'b0;
        end else begin
            st    <= nx;
            armed <= armed_nx;
        end
    end

    assign mode = st;
endmodule

// File: rtl/psram_sleep_ctrl.sv
module psram_sleep_ctrl
    import psram_sleep_pkg::*;
#(
    parameter int CLK_MHZ = 100,
    parameter int LOW_US  = 10,
    parameter int INIT_US = 150
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             cmd_rd,
    input  logic             cmd_wr,
    output logic             cmd_rd_ok,
    output logic             cmd_wr_ok,
    output logic             busy,
    output logic [1:0]       mode,
    output logic             refresh_en,
    output logic             refresh_full,
    output logic             data_lost,
    output logic [CFG_W-1:0] cfg_q
);
    localparam int LOW_CYC  = us_to_cycles(CLK_MHZ, LOW_US);
    localparam int INIT_CYC = us_to_cycles(CLK_MHZ, INIT_US);

    pmode_t   cur;
    logic     qual, init_done, wr_acc, sw_lock;
    refresh_t rf;

    psram_low_qual #(.LOW_CYC(LOW_CYC)) u_qual (
        .clk(clk), .rst(rst), .sleep_n(sleep_n), .qual(qual)
    );

    psram_init_timer #(.INIT_CYC(INIT_CYC)) u_timer (
        .clk(clk), .rst(rst), .run(cur == PM_INIT), .done(init_done)
    );

    psram_mode_fsm u_fsm (
        .clk(clk), .rst(rst), .sleep_n(sleep_n), .qual(qual),
        .sel_partial(cfg_q[SEL_BIT]), .lock(sw_lock),
        .wr_acc(wr_acc), .wr_sel(cfg_wdata[SEL_BIT]),
        .init_done(init_done), .mode(cur)
    );

    assign wr_acc = cfg_wr && (cur == PM_ACTIVE || cur == PM_PARTIAL);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= CFG_RESET;
            sw_lock   <= 1'b0;
            data_lost <= 1'b0;
        end else begin
            if (wr_acc) begin
                cfg_q   <= cfg_wdata;
                sw_lock <= 1'b1;
            end
            if (cur == PM_DEEP || (cur == PM_PARTIAL && !cfg_q[SCOPE_BIT]))
                data_lost <= 1'b1;
        end
    end

    assign rf           = refresh_for(cur, cfg_q[SCOPE_BIT]);
    assign refresh_en   = rf.en;
    assign refresh_full = rf.full;
    assign busy         = (cur != PM_ACTIVE);
    assign cmd_rd_ok    = cmd_rd && (cur == PM_ACTIVE);
    assign cmd_wr_ok    = cmd_wr && (cur == PM_ACTIVE);
    assign mode         = cur;
endmodule

// File: rtl/psram_sleep_chk.sv
module psram_sleep_chk
    import psram_sleep_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             sleep_n,
    input logic             cfg_wr,
    input logic [1:0]       mode,
    input logic             busy,
    input logic             refresh_en,
    input logic             data_lost,
    input logic             cmd_rd_ok,
    input logic             cmd_wr_ok,
    input logic             sw_lock,
    input logic [CFG_W-1:0] cfg_q
);
    AST_CMD_GATED: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!cmd_rd_ok && !cmd_wr_ok)); // R6

    AST_DEEP_NO_REFRESH: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_DEEP) |-> !refresh_en); // R3

    AST_NO_SW_DEEP: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_ACTIVE && cfg_wr) |=> (mode != PM_DEEP)); // R9

    AST_DEEP_WAKE: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_DEEP && sleep_n) |=> (mode == PM_INIT)); // R5

    AST_LOCKED_NO_PIN_PARTIAL: assert property (@(posedge clk) disable iff (rst)
        (sw_lock && mode == PM_ACTIVE && !cfg_wr) |=> (mode != PM_PARTIAL)); // R8

    AST_LOST_STICKY: assert property (@(posedge clk) disable iff (rst)
        !$fell(data_lost)); // R12

    AST_WR_IGNORED_ASLEEP: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_DEEP || mode == PM_INIT) |=> $stable(cfg_q)); // R10
endmodule

bind psram_sleep_ctrl psram_sleep_chk u_chk (
    .clk(clk), .rst(rst), .sleep_n(sleep_n), .cfg_wr(cfg_wr),
    .mode(mode), .busy(busy), .refresh_en(refresh_en),
    .data_lost(data_lost), .cmd_rd_ok(cmd_rd_ok), .cmd_wr_ok(cmd_wr_ok),
    .sw_lock(sw_lock), .cfg_q(cfg_q)
);

// File: tb/psram_sleep_ctrl_bench.sv
module psram_sleep_ctrl_bench;
    localparam int CLK_MHZ  = 1;
    localparam int LOW_US   = 10;
    localparam int INIT_US  = 150;
    localparam int LOW_CYC  = CLK_MHZ * LOW_US;
    localparam int INIT_CYC = CLK_MHZ * INIT_US;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sleep_n = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       cmd_rd = 1'b0;
    logic       cmd_wr = 1'b0;
    logic       cmd_rd_ok, cmd_wr_ok, busy, refresh_en, refresh_full, data_lost;
    logic [1:0] mode;
    logic [7:0] cfg_q;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    psram_sleep_ctrl #(.CLK_MHZ(CLK_MHZ), .LOW_US(LOW_US), .INIT_US(INIT_US)) u_psram_sleep_ctrl (
        .clk(clk), .rst(rst), .sleep_n(sleep_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_rd_ok(cmd_rd_ok), .cmd_wr_ok(cmd_wr_ok),
        .busy(busy), .mode(mode), .refresh_en(refresh_en), .refresh_full(refresh_full),
        .data_lost(data_lost), .cfg_q(cfg_q)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [7:0] d);
        cfg_wr = 1'b1;
        cfg_wdata = d;
        step(1);
        cfg_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // R11 reset state
        chk("R11", "mode", mode, 0);
        chk("R11", "busy", busy, 0);
        chk("R11", "refresh_en", refresh_en, 1);
        chk("R11", "refresh_full", refresh_full, 1);
        chk("R11", "data_lost", data_lost, 0);
        chk("R11", "cfg_q", cfg_q, 8'h11);

        // R1/R2 pin-initiated partial refresh, full scope
        sleep_n = 1'b0;
        step(LOW_CYC + 1);
        chk("R1", "mode at threshold", mode, 0);
        step(1);
        chk("R2", "mode partial", mode, 1);
        chk("R2", "refresh_full", refresh_full, 1);
        chk("R2", "refresh_en", refresh_en, 1);
        cmd_rd = 1'b1; cmd_wr = 1'b1;
        step(1);
        chk("R6", "rd_ok asleep", cmd_rd_ok, 0);
        chk("R6", "wr_ok asleep", cmd_wr_ok, 0);
        chk("R6", "busy asleep", busy, 1);
        sleep_n = 1'b1;
        step(1);
        chk("R4", "immediate exit", mode, 0);
        chk("R6", "rd_ok active", cmd_rd_ok, 1);
        chk("R6", "wr_ok active", cmd_wr_ok, 1);
        chk("R12", "no loss full scope", data_lost, 0);
        cmd_rd = 1'b0; cmd_wr = 1'b0;

        // R7 software entry with scope none
        cfg_write(8'h10);
        chk("R7", "sw partial", mode, 1);
        chk("R2", "scope none en", refresh_en, 0);
        chk("R2", "scope none full", refresh_full, 0);
        step(4);
        chk("R7", "held without pin pulse", mode, 1);
        chk("R12", "lost after none scope", data_lost, 1);
        sleep_n = 1'b0;
        step(1);
        sleep_n = 1'b1;
        step(1);
        chk("R7", "exit after pin pulse", mode, 0);

        // R8 lock: long low pin with bit 4 set does nothing
        sleep_n = 1'b0;
        step(LOW_CYC + 6);
        chk("R8", "locked pin", mode, 0);
        sleep_n = 1'b1;
        step(2);

        // R9 software write with bit 4 clear
        cfg_write(8'h01);
        step(2);
        chk("R9", "no sw deep", mode, 0);
        chk("R9", "cfg_q", cfg_q, 8'h01);

        // R1 sweep of low pulse lengths, deep power-down selected
        for (int len = 1; len <= LOW_CYC + 2; len++) begin
            sleep_n = 1'b0;
            step(len);
            sleep_n = 1'b1;
            step(3);
            chk("R1", $sformatf("pulse len %0d", len), mode, (len > LOW_CYC) ? 3 : 0);
            if (len > LOW_CYC) step(INIT_CYC + 2);
            chk("R1", "back to active", mode, 0);
        end

        // R3/R5/R10 deep power-down and wake
        sleep_n = 1'b0;
        step(LOW_CYC + 2);
        chk("R3", "deep mode", mode, 2);
        chk("R3", "refresh off", refresh_en, 0);
        chk("R3", "scope off", refresh_full, 0);
        step(1);
        chk("R12", "lost in deep", data_lost, 1);
        cfg_write(8'h11);
        chk("R10", "write ignored in deep", cfg_q, 8'h01);
        sleep_n = 1'b1;
        step(1);
        chk("R5", "init start", mode, 3);
        cfg_write(8'h11);
        chk("R10", "write ignored in init", cfg_q, 8'h01);
        cmd_rd = 1'b1;
        step(INIT_CYC - 2);
        chk("R5", "last init cycle", mode, 3);
        chk("R6", "rd_ok during init", cmd_rd_ok, 0);
        step(1);
        chk("R5", "active after init", mode, 0);
        chk("R6", "rd_ok after init", cmd_rd_ok, 1);
        cmd_rd = 1'b0;

        // R12 sticky until reset
        step(5);
        chk("R12", "still lost", data_lost, 1);
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        step(1);
        chk("R11", "lost cleared by reset", data_lost, 0);
        chk("R11", "cfg reset", cfg_q, 8'h11);

        // R8 lock cleared by reset: pin partial works again
        sleep_n = 1'b0;
        step(LOW_CYC + 2);
        chk("R8", "unlocked after reset", mode, 1);
        sleep_n = 1'b1;
        step(1);
        chk("R4", "exit again", mode, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule